// File: doc/BRIEF.md
# 32-bit SEC-DED Codec

This block protects a 32-bit data word with a 7-bit check word so that any single flipped bit in the 39 stored bits is corrected and any two flipped bits are detected. It is purely combinational and has two independent halves. The generate half turns a data word into the 7 check bits that are written to memory next to it. The check half takes a 39-bit word read back from memory, made of 32 data bits and 7 check bits. It returns the syndrome, the corrected data and two active-low flags. One flag reports any error. The other reports an error that cannot be corrected.

Each check bit is the parity of a fixed subset of the data bits. The subsets come from a check matrix with one 7-bit column per data bit. Every column has either three or five ones, so the table holds only odd-weight columns. The table is computed from parameters and is not written out. A fixed inversion mask is applied to the check bits both when they are generated and when they are checked. This stops a memory that reads back as all zeros or all ones from passing as a clean word. The syndrome is exposed so that system software can locate the failing bit.

Top module: `secded_codec`

## Requirements
- R1: `gen_check_o[j]` is the XOR of every data bit whose matrix column has bit j set, XORed with `CHK_INVERT[j]`. Data bit i takes column i. Columns 0 to NUM_LIGHT-1 are the 7-bit values of weight three in ascending order. The remaining columns are the values of weight five in ascending order. The default `CHK_INVERT` is 7'b0001100.
- R2: Every matrix column has weight three or five. A single flipped data bit therefore gives a syndrome with exactly three or five ones.
- R3: `chk_syndrome_o` equals `chk_check_i` XOR the check bits recomputed from `chk_data_i`. When the syndrome is zero, both flags are high and `chk_data_o` equals `chk_data_i`.
- R4: When exactly one data bit of the stored word is flipped, the following hold:
  - the syndrome equals that bit's column;
  - `chk_err_n_o` is low and `chk_multi_n_o` is high;
  - `chk_data_o` holds the original data.
- R5: When exactly one check bit is flipped, the syndrome is one-hot on that bit, `chk_err_n_o` is low, `chk_multi_n_o` is high and `chk_data_o` equals `chk_data_i`.
- R6: When any two of the 39 stored bits are flipped, both flags are low and `chk_data_o` equals `chk_data_i`.
- R7: A nonzero syndrome of odd weight that is neither one-hot nor a data column drives both flags low and passes `chk_data_i` through unchanged.
- R8: A stored word of all zeros, or of all ones, across the 39 bits drives `chk_err_n_o` low. With the default parameters, both flags go low.
- R9: `chk_multi_n_o` is never low while `chk_err_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gen_data_i | input | 32 | Data word to encode |
| gen_check_o | output | 7 | Check bits for `gen_data_i` |
| chk_data_i | input | 32 | Data part of the stored word |
| chk_check_i | input | 7 | Check part of the stored word |
| chk_data_o | output | 32 | Corrected data |
| chk_syndrome_o | output | 7 | Syndrome of the stored word |
| chk_err_n_o | output | 1 | Low when any error is seen |
| chk_multi_n_o | output | 1 | Low when the error cannot be corrected |

## Verification
The bench builds the block with its defaults: 32 data bits, 7 check bits, 16 weight-three columns and inversion mask 7'b0001100. At this size the stored word has only 39 bit positions, so every single-bit and every one of the 741 double-bit injections can be tried on more than one data pattern. Every odd-weight syndrome that matches no column can also be reached by XORing it into a valid check word. The same defaults place the all-zero word on an even-weight syndrome and the all-one word on the weight-seven syndrome, so both rails are exercised as uncorrectable.

// File: rtl/secded_pkg.sv
// Shared types for the SEC-DED codec.
// Assumes: nothing beyond IEEE 1800-2017.
package secded_pkg;

    // Classification of a stored word, as seen from its syndrome.
    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_DATA_BIT  = 2'd1,
        ERR_CHECK_BIT = 2'd2,
        ERR_UNCORR    = 2'd3
    } err_class_e;

endpackage

// File: rtl/secded_parity.sv
// Parity tree: forms CHK_W check bits from a DATA_W data word.
// Each check bit is the XOR of the data bits selected by one row of the
// column table COLS, then inverted where INVERT has a one.
// Assumes: COLS packs column i in bits [i*CHK_W +: CHK_W].
module secded_parity #(
    parameter int                        DATA_W = 32,
    parameter int                        CHK_W  = 7,
    parameter logic [DATA_W*CHK_W-1:0]   COLS   = '0,
    parameter logic [CHK_W-1:0]          INVERT = '0
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  check_o
);

    // Gathers, for one row, the data bits that take part in it.
    function automatic logic [DATA_W-1:0] row_mask(input int row);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = COLS[i*CHK_W + row];
        end
        return m;
    endfunction

    // One XOR tree per check bit.
    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam logic [DATA_W-1:0] MASK = row_mask(r);
        assign check_o[r] = (^(data_i & MASK)) ^ INVERT[r];
    end

endmodule

// File: rtl/secded_locate.sv
// Syndrome locator: matches the syndrome against every data column and
// classifies the stored word.
// Assumes: all columns in COLS are distinct, odd weight and not one-hot,
// so at most one flip bit can be set.
module secded_locate
    import secded_pkg::*;
#(
    parameter int                        DATA_W = 32,
    parameter int                        CHK_W  = 7,
    parameter logic [DATA_W*CHK_W-1:0]   COLS   = '0
) (
    input  logic [CHK_W-1:0]  syndrome_i,
    output logic [DATA_W-1:0] flip_o,
    output err_class_e        class_o
);

    // One comparator per data column.
    for (genvar i = 0; i < DATA_W; i++) begin : g_col
        localparam logic [CHK_W-1:0] COL = COLS[i*CHK_W +: CHK_W];
        assign flip_o[i] = (syndrome_i == COL);
    end

    // Sorts the syndrome into clean, data hit, check hit or uncorrectable.
    always_comb begin
        if (syndrome_i == '0) begin
            class_o = ERR_NONE;
        end else if (|flip_o) begin
            class_o = ERR_DATA_BIT;
        end else if ($onehot(syndrome_i)) begin
            class_o = ERR_CHECK_BIT;
        end else begin
            class_o = ERR_UNCORR;
        end
    end

endmodule

// File: rtl/secded_codec.sv
// SEC-DED codec top: a generate path (data to check bits) and a check path
// (stored word to syndrome, corrected data and active-low flags).
// The column table is computed: the first NUM_LIGHT columns are the
// weight-3 CHK_W-bit values in ascending order, the rest are weight-5
// values in ascending order.
// Assumes: enough such values exist for DATA_W columns. CHK_INVERT is
// chosen so that the all-zero and all-one stored words are not codewords.
module secded_codec
    import secded_pkg::*;
#(
    parameter int               DATA_W     = 32,
    parameter int               CHK_W      = 7,
    parameter int               NUM_LIGHT  = 16,
    parameter logic [CHK_W-1:0] CHK_INVERT = 7'b0001100
) (
    input  logic [DATA_W-1:0] gen_data_i,
    output logic [CHK_W-1:0]  gen_check_o,
    input  logic [DATA_W-1:0] chk_data_i,
    input  logic [CHK_W-1:0]  chk_check_i,
    output logic [DATA_W-1:0] chk_data_o,
    output logic [CHK_W-1:0]  chk_syndrome_o,
    output logic              chk_err_n_o,
    output logic              chk_multi_n_o
);

    localparam int CODE_SPACE = 1 << CHK_W;

    // Builds the packed column table from the weight rule above.
    function automatic logic [DATA_W*CHK_W-1:0] build_cols();
        logic [DATA_W*CHK_W-1:0] cols;
        logic [CHK_W-1:0]        cand;
        int                      idx;
        cols = '0;
        idx  = 0;
        for (int v = 0; v < CODE_SPACE; v++) begin
            cand = CHK_W'(v);
            if (($countones(cand) == 3) && (idx < NUM_LIGHT) && (idx < DATA_W)) begin
                cols[idx*CHK_W +: CHK_W] = cand;
                idx++;
            end
        end
        for (int v = 0; v < CODE_SPACE; v++) begin
            cand = CHK_W'(v);
            if (($countones(cand) == 5) && (idx < DATA_W)) begin
                cols[idx*CHK_W +: CHK_W] = cand;
                idx++;
            end
        end
        return cols;
    endfunction

    localparam logic [DATA_W*CHK_W-1:0] COLS = build_cols();

    logic [CHK_W-1:0]  recomputed;
    logic [DATA_W-1:0] flip;
    err_class_e        err_class;

    secded_parity #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .COLS   (COLS),
        .INVERT (CHK_INVERT)
    ) i_gen_parity (
        .data_i  (gen_data_i),
        .check_o (gen_check_o)
    );

    secded_parity #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .COLS   (COLS),
        .INVERT (CHK_INVERT)
    ) i_chk_parity (
        .data_i  (chk_data_i),
        .check_o (recomputed)
    );

    // Syndrome: stored check bits against those recomputed from stored data.
    assign chk_syndrome_o = chk_check_i ^ recomputed;

    secded_locate #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .COLS   (COLS)
    ) i_locate (
        .syndrome_i (chk_syndrome_o),
        .flip_o     (flip),
        .class_o    (err_class)
    );

    // Repair: invert the located data bit, nothing otherwise.
    assign chk_data_o = chk_data_i ^ flip;

    // Flags: any error drops err_n, an uncorrectable one also drops multi_n.
    always_comb begin
        chk_err_n_o   = (err_class == ERR_NONE);
        chk_multi_n_o = (err_class != ERR_UNCORR);
    end

endmodule

// File: rtl/secded_codec_chk.sv
// Checker for secded_codec: relates the syndrome, the flags and the data
// path at the ports. Purely combinational, so immediate assertions are used.
// Assumes: attached by the bind statement at the end of this file.
module secded_codec_chk #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 7
) (
    input logic [DATA_W-1:0] chk_data_i,
    input logic [DATA_W-1:0] chk_data_o,
    input logic [CHK_W-1:0]  chk_syndrome_o,
    input logic              chk_err_n_o,
    input logic              chk_multi_n_o
);

    // Port-level consistency between syndrome, flags and data.
    always_comb begin
        p_clean_r3: assert ((chk_syndrome_o != '0) ||
                            (chk_err_n_o && chk_multi_n_o && (chk_data_o == chk_data_i)))
            else $error("clean syndrome must leave flags high and data untouched");
        p_onehot_r5: assert (($countones(chk_syndrome_o) != 1) ||
                             (!chk_err_n_o && chk_multi_n_o && (chk_data_o == chk_data_i)))
            else $error("one-hot syndrome must flag a single check-bit error");
        p_even_r6: assert ((chk_syndrome_o == '0) || chk_syndrome_o[0] ^ (^chk_syndrome_o[CHK_W-1:1]) ||
                           (!chk_err_n_o && !chk_multi_n_o))
            else $error("even-weight syndrome must drop both flags");
        p_fix_one_r4: assert (!(!chk_err_n_o && chk_multi_n_o && ($countones(chk_syndrome_o) > 1)) ||
                              ($countones(chk_data_o ^ chk_data_i) == 1))
            else $error("correctable data error must invert exactly one bit");
        p_pass_r7: assert (chk_multi_n_o || (chk_data_o == chk_data_i))
            else $error("uncorrectable word must pass through unchanged");
        p_flags_r9: assert (chk_multi_n_o || !chk_err_n_o)
            else $error("multi flag low while err flag high");
    end

endmodule

bind secded_codec secded_codec_chk #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W)
) i_secded_codec_chk (
    .chk_data_i     (chk_data_i),
    .chk_data_o     (chk_data_o),
    .chk_syndrome_o (chk_syndrome_o),
    .chk_err_n_o    (chk_err_n_o),
    .chk_multi_n_o  (chk_multi_n_o)
);

// File: tb/test_secded_codec.sv
// Bench for secded_codec: a behavioural reference model (column search by
// weight, per-bit encode, linear syndrome search) compared on every clock.
module test_secded_codec;

    localparam int          DW  = 32;
    localparam int          CW  = 7;
    localparam int          NL  = 16;
    localparam logic [6:0]  INV = 7'b0001100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] gen_data, chk_data, data_out;
    logic [6:0]  gen_check, chk_check, syndrome;
    logic        err_n, multi_n;

    int  checks   = 0;
    int  failures = 0;
    bit  done     = 1'b0;

    secded_codec #(
        .DATA_W     (DW),
        .CHK_W      (CW),
        .NUM_LIGHT  (NL),
        .CHK_INVERT (INV)
    ) i_secded_codec (
        .gen_data_i     (gen_data),
        .gen_check_o    (gen_check),
        .chk_data_i     (chk_data),
        .chk_check_i    (chk_check),
        .chk_data_o     (data_out),
        .chk_syndrome_o (syndrome),
        .chk_err_n_o    (err_n),
        .chk_multi_n_o  (multi_n)
    );

    // Column of data bit idx, found by counting candidate values.
    function automatic logic [6:0] m_col(input int idx);
        int found = 0;
        for (int v = 0; v < 128; v++) begin
            if ($countones(v) == 3 && found < NL) begin
                if (found == idx) return v[6:0];
                found++;
            end
        end
        for (int v = 0; v < 128; v++) begin
            if ($countones(v) == 5) begin
                if (found == idx) return v[6:0];
                found++;
            end
        end
        return 7'd0;
    endfunction

    // Check bits by summing the columns of set data bits.
    function automatic logic [6:0] m_enc(input logic [31:0] d);
        logic [6:0] p = '0;
        for (int i = 0; i < DW; i++) if (d[i]) p ^= m_col(i);
        return p ^ INV;
    endfunction

    function automatic bit m_is_col(input logic [6:0] s);
        for (int i = 0; i < DW; i++) if (m_col(i) == s) return 1'b1;
        return 1'b0;
    endfunction

    task automatic fail_line(input string tag, input string what,
                             input logic [31:0] act, input logic [31:0] exp);
        failures++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    task automatic expect_val(input string tag, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) fail_line(tag, what, act, exp);
    endtask

    // Drive one stored word, then compare every output with the model.
    task automatic apply(input logic [31:0] d, input logic [6:0] c, input string tag);
        logic [6:0]  e_syn;
        logic [31:0] e_data;
        logic        e_err_n, e_multi_n;
        @(posedge clk);
        #1;
        chk_data  = d;
        chk_check = c;
        gen_data  = d;
        @(negedge clk);
        e_syn     = c ^ m_enc(d);
        e_data    = d;
        e_err_n   = (e_syn == '0);
        e_multi_n = 1'b1;
        if (e_syn != '0) begin
            if (m_is_col(e_syn)) begin
                for (int i = 0; i < DW; i++) if (m_col(i) == e_syn) e_data[i] = ~d[i];
            end else if ($countones(e_syn) != 1) begin
                e_multi_n = 1'b0;
            end
        end
        checks++;
        if (syndrome !== e_syn || data_out !== e_data ||
            err_n !== e_err_n || multi_n !== e_multi_n) begin
            failures++;
            $display("FAIL %s syn=%h/%h data=%h/%h err_n=%b/%b multi_n=%b/%b (actual/expected)",
                     tag, syndrome, e_syn, data_out, e_data, err_n, e_err_n, multi_n, e_multi_n);
        end
        expect_val("R1", "gen_check", 32'(gen_check), 32'(m_enc(d)));
        checks++;
        if (!multi_n && err_n) fail_line("R9", "flags err_n/multi_n", {err_n, multi_n}, 32'b01);
    endtask

    logic [31:0] pats [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5C3_1E77, 32'h0F0F_5A3C};

    // Main sequence.
    initial begin
        gen_data  = '0;
        chk_data  = '0;
        chk_check = '0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R3: first word after reset is a clean zero word.
        apply(32'h0, m_enc(32'h0), "R3 clean zero word");

        // R1/R3: clean codewords, walking one and fixed patterns.
        for (int i = 0; i < DW; i++) apply(32'h1 << i, m_enc(32'h1 << i), "R3 clean walking one");
        foreach (pats[p]) apply(pats[p], m_enc(pats[p]), "R3 clean pattern");

        // R4 and R2: every single data-bit error.
        foreach (pats[p]) begin
            for (int i = 0; i < DW; i++) begin
                apply(pats[p] ^ (32'h1 << i), m_enc(pats[p]), "R4 single data error");
                checks++;
                if (!($countones(syndrome) inside {3, 5}))
                    fail_line("R2", "syndrome weight", 32'($countones(syndrome)), 32'd3);
                expect_val("R4", "corrected data", data_out, pats[p]);
            end
        end

        // R5: every single check-bit error.
        foreach (pats[p]) begin
            for (int j = 0; j < CW; j++) begin
                apply(pats[p], m_enc(pats[p]) ^ (7'h1 << j), "R5 single check error");
                expect_val("R5", "syndrome", 32'(syndrome), 32'(7'h1 << j));
            end
        end

        // R6: every pair of flipped bits across the 39-bit word.
        for (int p = 0; p < 4; p += 2) begin
            for (int a = 0; a < DW + CW; a++) begin
                for (int b = a + 1; b < DW + CW; b++) begin
                    logic [38:0] word;
                    word = {m_enc(pats[p]), pats[p]};
                    word[a] = ~word[a];
                    word[b] = ~word[b];
                    apply(word[31:0], word[38:32], "R6 double error");
                    expect_val("R6", "flags", {err_n, multi_n}, 32'b00);
                end
            end
        end

        // R7: odd-weight syndromes that match no column and are not one-hot.
        for (int s = 0; s < 128; s++) begin
            if ($countones(s) % 2 == 1 && $countones(s) > 1 && !m_is_col(s[6:0])) begin
                apply(pats[2], m_enc(pats[2]) ^ s[6:0], "R7 uncorrectable odd syndrome");
                expect_val("R7", "flags", {err_n, multi_n}, 32'b00);
                expect_val("R7", "data passthrough", data_out, pats[2]);
            end
        end

        // R8: all-zero and all-one stored words.
        apply(32'h0, 7'h00, "R8 all zero word");
        expect_val("R8", "flags all zero", {err_n, multi_n}, 32'b00);
        apply(32'hFFFF_FFFF, 7'h7F, "R8 all one word");
        expect_val("R8", "flags all one", {err_n, multi_n}, 32'b00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule